// File: doc/BRIEF.md
# Quarter-Rate to Full-Rate Mux-Tree Serializer

The block turns a stream of four-bit parallel words into a single serial stream at the bit rate. It is built as a tree of three two-input selectors. Two first-stage selectors are steered by a pair of quadrature quarter-rate phases. Each one yields a half-rate stream: one carries the even bits 0 and 2, the other the odd bits 1 and 3. A final selector, steered at half the bit rate, interleaves the two streams into the full-rate output.

All selector controls come from the states of one two-flop twisted-ring (Johnson) phase generator, which runs on the bit clock. No chain of divide-by-two stages is used. The parallel word is captured on the phase-zero edge. The even branch then passes through a one-cycle flop stage. The odd branch passes through a flop and then a latch that is transparent while the clock is low, which gives one and a half cycles of delay. Because of this, every selector input changes away from the period in which it is selected.

The surrounding logic presents a new word whenever `ld_o` is high, and the block emits it without gaps.

Top module: `mux4_serializer`

## Requirements
- R1: While `rst_n` is low, `dout` is 0 and `ld_o` is 0. The phase generator restarts at its first state.
- R2: After reset is released, `ld_o` is first high in the fourth cycle. It is then high for exactly one cycle out of every four.
- R3: `din` is captured only at the rising clock edge that ends a cycle in which `ld_o` is high. Values on `din` at any other edge have no effect on `dout`.
- R4: Bit 0 of a captured word appears on `dout` in the third cycle after the capture edge.
- R5: The four bits of a word leave LSB first (bit 0, 1, 2, 3), one per cycle. Bits 0 and 2 travel through the even branch and bits 1 and 3 through the odd branch.
- R6: Consecutive words are sent back to back. Bit 0 of a word directly follows bit 3 of the previous word.
- R7: The odd-branch half-cycle stage holds its value steady across every bit period in which the final selector picks the odd stream. Bits 1 and 3 are therefore correct even while the next word is already captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 4 | Parallel word, bit 0 sent first |
| ld_o | output | 1 | High in the cycle whose closing edge captures `din` |
| dout | output | 1 | Full-rate serial data |

## Verification
The sweep sends every ordered pair of four-bit words back to back and drives random values onto `din` in every cycle where no capture is due. A design that sampled `din` on the wrong edge would therefore emit noise. A design with the wrong latency or wrong selector phases would shift or swap bits, for example producing 0,2,1,3 instead of LSB first. The pairs 0→15 and 15→0 expose a gap or overlap at the word boundary. Any odd-branch stage that updated too early would corrupt bit 3 as soon as the following word was loaded.

// File: rtl/mux4_serializer.sv
module mux4_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] din,
  output logic       ld_o,
  output logic       dout
);

  logic       ph_i, ph_q;
  logic [3:0] cap;
  logic [1:0] ev_d;
  logic [1:0] od_p;
  logic [1:0] od_h;
  logic       half;
  logic       mux_a, mux_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_i <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      ph_i <= ~ph_q;
      ph_q <= ph_i;
    end
  end

  assign ld_o = ~ph_i & ph_q;
  assign half = ph_i ^ ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cap <= '0;
    else if (ld_o) cap <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_d <= '0;
      od_p <= '0;
    end else begin
      ev_d <= {cap[2], cap[0]};
      od_p <= {cap[3], cap[1]};
    end
  end

  always_latch begin
    if (!clk) od_h = od_p;
  end

  assign mux_a = ph_q ? ev_d[1] : ev_d[0];
  assign mux_b = ph_i ? od_h[0] : od_h[1];

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= half ? mux_a : mux_b;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (dout == 1'b0 && ld_o == 1'b0));

  p_ld_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_o |=> !ld_o ##1 !ld_o ##1 !ld_o ##1 ld_o);

  p_lat_b0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_o, 3) |-> dout == $past(din[0], 3));

  p_lat_b1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_o, 4) |-> dout == $past(din[1], 4));

  p_lat_b2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_o, 5) |-> dout == $past(din[2], 5));

  p_lat_b3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_o, 6) |-> dout == $past(din[3], 6));

  p_odd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !half |-> $stable(od_h));

endmodule

// File: tb/mux4_serializer_bench.sv
module mux4_serializer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] din = '0;
  logic       ld_o, dout;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_ld = -1;
  int rel_cyc = 0;
  bit done = 0;
  logic exp_bit [0:4095];
  bit   exp_vld [0:4095];

  always #2.5 clk = ~clk;

  mux4_serializer u_mux4_serializer (
    .clk(clk), .rst_n(rst_n), .din(din), .ld_o(ld_o), .dout(dout)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  initial begin
    int nwords;
    nwords = 0;
    for (int i = 0; i < 4096; i++) exp_vld[i] = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 reset dout", dout, 1'b0);
      chk("R1 reset ld_o", ld_o, 1'b0);
    end
    rst_n = 1'b1;
    rel_cyc = 0;
    while (nwords < 512 || cyc < rel_cyc + 4 * 512 + 12) begin
      if (exp_vld[cyc]) chk("R4/R5/R6/R7 serial bit", dout, exp_bit[cyc]);
      if (ld_o) begin
        if (last_ld < 0) chk("R2 first ld_o cycle", (cyc == 3) ? 1'b1 : 1'b0, 1'b1);
        else chk("R2 ld_o spacing", (cyc - last_ld == 4) ? 1'b1 : 1'b0, 1'b1);
        last_ld = cyc;
        if (nwords < 512) begin
          logic [3:0] w;
          w = (nwords[0] == 1'b0) ? nwords[8:5] : nwords[4:1];
          din = w;
          for (int j = 0; j < 4; j++) begin
            exp_bit[cyc + 3 + j] = w[j];
            exp_vld[cyc + 3 + j] = 1;
          end
          nwords++;
        end else din = 4'($urandom);
      end else begin
        if (last_ld >= 0 && cyc - last_ld > 4)
          chk("R2 ld_o missing", 1'b0, 1'b1);
        din = 4'($urandom);   // R3: must be ignored
      end
      @(negedge clk);
      cyc++;
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule